// File: doc/BRIEF.md
# Audio DMA Address Generator with Limit Interrupt

This block is one channel of a bus-master address engine for an audio stream. It holds a byte pointer into a circular buffer in memory. The buffer is described by a start address and a protection address, where the protection address equals the start address plus the buffer size. Each dword transfer that the bus accepts moves the pointer forward by four bytes. When the pointer lands on the protection address, the current burst ends, and the next transfer goes to the start address again. The pointer is always visible, so software can compute its position in the buffer. Software reads an offset equal to the buffer size as offset zero.

A page word holds a 4-bit limit code L in bits 7:4 and a translation-enable flag in bit 11. Translation is not implemented, so that flag has no effect. When L is not zero, the block pulses an event each time the pointer moves onto an address whose low 5+L bits are all zero. Those addresses are boundaries every 2^(5+L) bytes, which runs from 64 bytes up to 1 MB.

Requests on the bus are gated against the fill level of the FIFO. In write mode, the FIFO level counts valid data. In read mode, the free space (depth minus level) counts instead. A request starts only when that count reaches the programmed threshold. A request then lasts for one burst, unless the protection address cuts it short.

Top module: `audioDmaAddrGen`

## Requirements
- R1: While reset is asserted and directly after it, `busReq` is 0, `curPtr` is 0 and `limitEvt` is 0.
- R2: A `restart` pulse loads `curPtr` with `baseAddr` at the next clock edge, and any burst in progress ends.
- R3: A beat is accepted at a clock edge where `busReq`, `busAck` and `xferEn` are all 1. Each accepted beat sets `curPtr` to `busAddr + 4`. Without an accepted beat, `curPtr` keeps its value.
- R4: `busAddr` equals `curPtr`, except when `curPtr` equals `protAddr`; then `busAddr` equals `baseAddr`. A beat that makes `curPtr` equal to `protAddr` ends the burst.
- R5: `limitEvt` is high for one cycle, in the cycle after an accepted beat, exactly when the new `curPtr` has its low 5+L bits all zero. L is `pageWord[7:4]`. This includes a beat that lands on `protAddr`.
- R6: When L = 0, `limitEvt` stays 0.
- R7: A burst lasts 2^`burstCode` accepted beats (codes 0..7 give 1..128 beats). After the last beat, `busReq` drops for at least one cycle.
- R8: `busReq` rises only after a cycle in which `xferEn` was 1 and the available count was at least the threshold. `threshCode` 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 16 dwords.
- R9: With `writeMode` = 1, the available count is `fifoLevel`. With `writeMode` = 0, it is FIFO_DEPTH − `fifoLevel`.
- R10: A cycle with `xferEn` = 0 ends any burst, so `busReq` is 0 after the next edge. A `busAck` in that cycle does not move the pointer.
- R11: `pageWord[11]` (translation enable) has no effect on addresses or events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Loads the pointer with the buffer start |
| xferEn | input | 1 | Transfer enable for the channel |
| writeMode | input | 1 | 1: threshold counts valid data; 0: threshold counts free space |
| baseAddr | input | ADDR_W | Buffer start byte address |
| protAddr | input | ADDR_W | Buffer start plus buffer size |
| pageWord | input | 12 | Limit code in bits 7:4, translation enable in bit 11 |
| burstCode | input | 3 | Burst length code, 2^code dwords |
| threshCode | input | 2 | Threshold code: 1, 4, 8 or 16 dwords |
| fifoLevel | input | LVL_W | Number of dwords held in the FIFO |
| busAck | input | 1 | The bus accepts the current dword beat |
| busReq | output | 1 | Bus request, high for the length of a burst |
| busAddr | output | ADDR_W | Byte address of the current beat |
| curPtr | output | ADDR_W | Current pointer, read back by software |
| limitEvt | output | 1 | One-cycle pulse on a limit-boundary crossing |

## Verification
The bench builds the block with ADDR_W = 24 and FIFO_DEPTH = 16. With 24 address bits, all limit codes up to the 1 MB boundary can be represented, while the buffers in the tests stay small. A depth of 16 makes the largest threshold equal to a completely full (or completely empty) FIFO. Small buffers let a 64-beat burst run into the protection address on an aligned boundary, so the wrap, the truncated burst and a boundary event at the wrap point all occur in a few hundred cycles.

// File: rtl/audioDmaPkg.sv
package audioDmaPkg;
  typedef enum logic {ST_IDLE, ST_BURST} dmaState_t;

  typedef struct packed {
    logic advance;
    logic reload;
  } dmaStrobe_t;
endpackage

// File: rtl/audioDmaCtrl.sv
module audioDmaCtrl
  import audioDmaPkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             xferEn,
  input  logic             writeMode,
  input  logic [2:0]       burstCode,
  input  logic [1:0]       threshCode,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             busAck,
  input  logic             landsOnProt,
  output logic             busReq,
  output dmaStrobe_t       strobe
);
  localparam int BEAT_W = 8;

  dmaState_t         state;
  logic [BEAT_W-1:0] beatsLeft;
  logic [BEAT_W-1:0] burstLen;
  logic [LVL_W-1:0]  avail;
  logic [LVL_W-1:0]  thrVal;
  logic              canStart;

  always_comb begin
    avail = writeMode ? fifoLevel : (LVL_W'(FIFO_DEPTH) - fifoLevel);
    case (threshCode)
      2'd0:    thrVal = LVL_W'(1);
      2'd1:    thrVal = LVL_W'(4);
      2'd2:    thrVal = LVL_W'(8);
      default: thrVal = LVL_W'(16);
    endcase
    burstLen = BEAT_W'(1) << burstCode;
    canStart = xferEn && (avail >= thrVal);
  end

  assign busReq         = (state == ST_BURST);
  assign strobe.reload  = restart;
  assign strobe.advance = busReq && busAck && xferEn && !restart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      beatsLeft <= '0;
    end else if (restart) begin
      state     <= ST_IDLE;
      beatsLeft <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (canStart) begin
            state     <= ST_BURST;
            beatsLeft <= burstLen;
          end
        end
        default: begin
          if (!xferEn) begin
            state <= ST_IDLE;
          end else if (busAck) begin
            beatsLeft <= beatsLeft - BEAT_W'(1);
            if (beatsLeft == BEAT_W'(1) || landsOnProt) state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R10: enable low ends the burst
  assert_en_low_drops_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    !xferEn |=> !busReq);

  // R8: a request starts only after the threshold was met
  assert_req_needs_threshold_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(xferEn && (avail >= thrVal)));

  // R7: after the last beat of a burst the request drops
  assert_burst_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && beatsLeft == BEAT_W'(1)) |=> !busReq);
endmodule

// File: rtl/audioDmaPath.sv
module audioDmaPath
  import audioDmaPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] protAddr,
  input  logic [3:0]        limitCode,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] curPtr,
  output logic              landsOnProt,
  output logic              limitEvt
);
  localparam int BOUND_BASE = 5;
  localparam logic [ADDR_W-1:0] DWORD_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] nextPtr;
  logic [ADDR_W-1:0] boundMask;
  logic              hitBound;

  always_comb begin
    busAddr     = (curPtr == protAddr) ? baseAddr : curPtr;
    nextPtr     = busAddr + DWORD_BYTES;
    landsOnProt = (nextPtr == protAddr);
    boundMask   = (ADDR_W'(1) << (BOUND_BASE + int'(limitCode))) - ADDR_W'(1);
    hitBound    = (limitCode != 4'd0) && ((nextPtr & boundMask) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr   <= '0;
      limitEvt <= 1'b0;
    end else if (strobe.reload) begin
      curPtr   <= baseAddr;
      limitEvt <= 1'b0;
    end else if (strobe.advance) begin
      curPtr   <= nextPtr;
      limitEvt <= hitBound;
    end else begin
      limitEvt <= 1'b0;
    end
  end

  // R3: the pointer holds without a beat or reload
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.reload) |=> $stable(curPtr));

  // R4: a beat taken at the protection address restarts from the base
  assert_wrap_to_base_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.reload && curPtr == protAddr)
      |=> curPtr == $past(baseAddr) + DWORD_BYTES);

  // R5: an event only follows an accepted beat
  assert_evt_after_beat_R5: assert property (@(posedge clk) disable iff (!rstN)
    limitEvt |-> $past(strobe.advance));

  // R6: limit code zero never produces an event
  assert_zero_limit_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    limitEvt |-> $past(limitCode) != 4'd0);
endmodule

// File: rtl/audioDmaAddrGen.sv
module audioDmaAddrGen
  import audioDmaPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic              xferEn,
  input  logic              writeMode,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] protAddr,
  input  logic [11:0]       pageWord,
  input  logic [2:0]        burstCode,
  input  logic [1:0]        threshCode,
  input  logic [LVL_W-1:0]  fifoLevel,
  input  logic              busAck,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] curPtr,
  output logic              limitEvt
);
  dmaStrobe_t strobe;
  logic       landsOnProt;
  logic       unusedPageBits;

  // translation enable (bit 11) and the other spare bits are not used
  assign unusedPageBits = ^{pageWord[11:8], pageWord[3:0]};

  audioDmaCtrl #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .restart     (restart),
    .xferEn      (xferEn),
    .writeMode   (writeMode),
    .burstCode   (burstCode),
    .threshCode  (threshCode),
    .fifoLevel   (fifoLevel),
    .busAck      (busAck),
    .landsOnProt (landsOnProt),
    .busReq      (busReq),
    .strobe      (strobe)
  );

  audioDmaPath #(.ADDR_W(ADDR_W)) i_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .baseAddr    (baseAddr),
    .protAddr    (protAddr),
    .limitCode   (pageWord[7:4]),
    .busAddr     (busAddr),
    .curPtr      (curPtr),
    .landsOnProt (landsOnProt),
    .limitEvt    (limitEvt)
  );
endmodule

// File: tb/test_audioDmaAddrGen.sv
`timescale 1ns/1ps
module test_audioDmaAddrGen;
  localparam int AW    = 24;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          restart = 1'b0;
  logic          xferEn = 1'b0;
  logic          writeMode = 1'b1;
  logic [AW-1:0] baseAddr = '0;
  logic [AW-1:0] protAddr = '0;
  logic [11:0]   pageWord = '0;
  logic [2:0]    burstCode = '0;
  logic [1:0]    threshCode = '0;
  logic [LW-1:0] fifoLevel = '0;
  logic          busAck = 1'b1;
  logic          busReq;
  logic [AW-1:0] busAddr;
  logic [AW-1:0] curPtr;
  logic          limitEvt;

  int nChecks = 0;
  int nFails  = 0;
  int curLimit = 0;
  int alignBad = 0;

  always #10 clk = ~clk;

  audioDmaAddrGen #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH)) i_audioDmaAddrGen (
    .clk(clk), .rstN(rstN), .restart(restart), .xferEn(xferEn),
    .writeMode(writeMode), .baseAddr(baseAddr), .protAddr(protAddr),
    .pageWord(pageWord), .burstCode(burstCode), .threshCode(threshCode),
    .fifoLevel(fifoLevel), .busAck(busAck), .busReq(busReq),
    .busAddr(busAddr), .curPtr(curPtr), .limitEvt(limitEvt)
  );

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doRestart(input logic [AW-1:0] b, input logic [AW-1:0] p);
    baseAddr = b; protAddr = p; restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  // enable, wait for a request, count beats and events until it drops
  task automatic runBurst(output int beats, output int evts, output logic [AW-1:0] firstAddr);
    int waitCnt = 0;
    beats = 0; evts = 0;
    xferEn = 1'b1;
    while (!busReq && waitCnt < 50) begin @(negedge clk); waitCnt++; end
    firstAddr = busAddr;
    while (busReq) begin
      @(negedge clk);
      beats++;
      if (limitEvt) begin
        evts++;
        if (curLimit != 0 && (curPtr & ((AW'(1) << (5 + curLimit)) - 1)) != 0) alignBad++;
      end
    end
    xferEn = 1'b0;
  endtask

  task automatic testReset();
    check("R1 busReq", busReq, 0);
    check("R1 curPtr", curPtr, 0);
    check("R1 limitEvt", limitEvt, 0);
  endtask

  task automatic testRestart();
    doRestart(24'h001000, 24'h001100);
    check("R2 curPtr", curPtr, 24'h001000);
    check("R4 busAddr", busAddr, 24'h001000);
  endtask

  task automatic testBurstLen();
    int b, e; logic [AW-1:0] fa;
    writeMode = 1'b1; fifoLevel = LW'(16); threshCode = 2'd0; pageWord = '0;
    burstCode = 3'd2;
    runBurst(b, e, fa);
    check("R7 beats code2", b, 4);
    check("R3 ptr after 4", curPtr, 24'h001010);
    check("R4 first addr", fa, 24'h001000);
    burstCode = 3'd0;
    runBurst(b, e, fa);
    check("R7 beats code0", b, 1);
    check("R3 ptr after 1", curPtr, 24'h001014);
  endtask

  task automatic testThreshold();
    writeMode = 1'b1; threshCode = 2'd2; fifoLevel = LW'(7); burstCode = 3'd0;
    xferEn = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8 below threshold", busReq, 0);
    end
    fifoLevel = LW'(8);
    @(negedge clk);
    check("R8 at threshold", busReq, 1);
    xferEn = 1'b0;
    @(negedge clk);
    check("R10 drop", busReq, 0);
  endtask

  task automatic testReadMode();
    writeMode = 1'b0; threshCode = 2'd1; fifoLevel = LW'(13); burstCode = 3'd0;
    xferEn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 free 3 below 4", busReq, 0);
    end
    fifoLevel = LW'(12);
    @(negedge clk);
    check("R9 free 4 requests", busReq, 1);
    xferEn = 1'b0;
    @(negedge clk);
    writeMode = 1'b1; fifoLevel = LW'(16); threshCode = 2'd0;
  endtask

  task automatic testEnableAndAck();
    logic [AW-1:0] p0;
    doRestart(24'h004000, 24'h004400);
    burstCode = 3'd7; busAck = 1'b0; xferEn = 1'b1;
    @(negedge clk);
    check("R7 req raised", busReq, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R3 no ack holds", curPtr, 24'h004000);
    end
    busAck = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R3 three beats", curPtr, 24'h00400c);
    xferEn = 1'b0;
    p0 = curPtr;
    @(negedge clk);
    check("R10 req low", busReq, 0);
    check("R10 ack ignored", curPtr, p0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R10 ptr stable", curPtr, p0);
  endtask

  task automatic testWrap();
    int b, e; logic [AW-1:0] fa;
    doRestart(24'h002000, 24'h002010);
    burstCode = 3'd3;
    runBurst(b, e, fa);
    check("R4 burst cut at prot", b, 4);
    check("R4 ptr at prot", curPtr, 24'h002010);
    check("R4 busAddr reloads base", busAddr, 24'h002000);
    burstCode = 3'd1;
    runBurst(b, e, fa);
    check("R4 first beat at base", fa, 24'h002000);
    check("R4 ptr after wrap", curPtr, 24'h002008);
  endtask

  task automatic testLimit();
    int b, e; logic [AW-1:0] fa;
    doRestart(24'h003000, 24'h003100);
    burstCode = 3'd5; pageWord = 12'h010; curLimit = 1; alignBad = 0;
    runBurst(b, e, fa);
    check("R5 64B events", e, 2);
    check("R5 events aligned", alignBad, 0);
    doRestart(24'h003000, 24'h003100);
    pageWord = 12'h000; curLimit = 0;
    runBurst(b, e, fa);
    check("R6 limit 0 no events", e, 0);
    doRestart(24'h003000, 24'h003100);
    burstCode = 3'd6; pageWord = 12'h030; curLimit = 3;
    runBurst(b, e, fa);
    check("R5 event on prot", e, 1);
    check("R5 ptr at prot", curPtr, 24'h003100);
    doRestart(24'h003000, 24'h003100);
    burstCode = 3'd5; pageWord = 12'h810; curLimit = 1; alignBad = 0;
    runBurst(b, e, fa);
    check("R11 events with bit 11", e, 2);
    check("R11 ptr with bit 11", curPtr, 24'h003080);
    check("R11 aligned", alignBad, 0);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRestart();
    testBurstLen();
    testThreshold();
    testReadMode();
    testEnableAndAck();
    testWrap();
    testLimit();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule